// File: doc/BRIEF.md
# Clock Divider and Output-Select Register

This block holds a single 16-bit control register on a simple two-cycle register bus. One field of the register picks how far the fast oscillator clock is divided to make the processor clock. The block produces that clock as a one-cycle enable strobe in the system-clock domain. A second field picks what drives an external clock-output pin: a software-written static level, an interface clock, the processor clock, or the system clock itself.

All internal clocks are enable strobes derived from the system clock. The interface clock is a fixed divide-by-2 strobe. The system-clock option is a constant-high strobe, because the system clock fires on every cycle.

The pin is registered, so it follows its selected source one cycle later. A ratio written mid-period is held back until the current divider period ends, so software never sees a shortened processor-clock period. The register has no mode gating: every access is treated the same way.

Top module: `clk_ratio_ctl`

## Requirements
- R1: Register bits 9:8 choose the processor-clock ratio: 00 divides by 8, 01 by 16, 10 by 32 and 11 by 64. `core_en` is high for exactly one system-clock cycle in every ratio-length period.
- R2: Register bits 6:5 choose the pin source: 00 is the static level bit, 01 is the interface strobe, 10 is the processor strobe and 11 is the system clock (constant high). The pin shows the selected source's value one system-clock cycle later.
- R3: Register bit 3 is a read/write level bit that resets to 0. It appears on the pin while bits 6:5 are 00.
- R4: Bits 15:10, 7, 4 and 2:0 always read as 0, and writing 1 to them changes no field.
- R5: An access starts when `req` is high at a clock edge while the bus is idle. `ready` is high only in the second cycle of the access. `rdata` carries the register image while `ready` is high and is 0 otherwise. A write takes effect at the edge that ends the second cycle.
- R6: Byte-lane enables decide what a write updates: `be[0]` gates bits 7:0 (source select and level bit), and `be[1]` gates bits 15:8 (ratio select). A write with both set updates the whole register.
- R7: A new ratio is adopted only at the edge that ends a divider period. The period running when the write lands, including one whose last edge is the write's commit edge, keeps the old ratio. The period after it uses the new ratio.
- R8: `if_en` is high on every second system-clock cycle. It is low in the first cycle after reset and high in the second.
- R9: Synchronous active-high `rst` clears all fields to 0, clears the pin, restarts the divider at count 0 with ratio 8, and idles the bus. The first `core_en` pulse comes in the 8th cycle after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled while the bus is idle |
| wr | input | 1 | 1 = write, 0 = read; held for the whole access |
| be | input | 2 | Byte-lane write enables, held for the whole access |
| wdata | input | 16 | Write data, held for the whole access |
| rdata | output | 16 | Register image while `ready` is high, otherwise 0 |
| ready | output | 1 | High in the second (completing) cycle of an access |
| core_en | output | 1 | Processor-clock enable strobe |
| if_en | output | 1 | Interface-clock enable strobe |
| clk_pin | output | 1 | Registered clock-output pin value |

## Verification
A register write that changes the ratio can land on the same edge where the divider reaches the end of its period. That edge is where the counter reloads and the active ratio is latched, so the two events collide there. The bench provokes this by syncing to a processor strobe at ratio 64 and waiting until the count is one below its limit. It then starts a write, so the write's commit edge equals the terminal-count edge. The result passes only if the next period is still 64 cycles long and the period after it is 8. A mid-period write from a known phase is also measured and must produce the same old-then-new sequence.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int unsigned BUS_W   = 16;
   localparam int unsigned LANE_W  = 8;
   localparam int unsigned LANES   = BUS_W / LANE_W;

   // Field placement inside the control word
   localparam int unsigned DIV_LSB = 8;
   localparam int unsigned DIV_W   = 2;
   localparam int unsigned SRC_LSB = 5;
   localparam int unsigned SRC_W   = 2;
   localparam int unsigned LVL_POS = 3;

   localparam logic [BUS_W-1:0] FIELD_MASK =
        (BUS_W'((1 << DIV_W) - 1) << DIV_LSB)
      | (BUS_W'((1 << SRC_W) - 1) << SRC_LSB)
      | (BUS_W'(1) << LVL_POS);

   typedef enum logic [SRC_W-1:0] {
      SRC_LEVEL = 2'b00,
      SRC_IFCLK = 2'b01,
      SRC_CORE  = 2'b10,
      SRC_SYS   = 2'b11
   } src_sel_e;

   typedef enum logic {
      ACC_IDLE = 1'b0,
      ACC_DONE = 1'b1
   } acc_state_e;

   typedef struct packed {
      logic [DIV_W-1:0] div_sel;
      src_sel_e         src;
      logic             lvl;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{div_sel: '0, src: SRC_LEVEL, lvl: 1'b0};

endpackage

// File: rtl/clkctl_bus.sv
module clkctl_bus
   import clkctl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic wr,
   output logic ready,
   output logic wr_commit
);

   acc_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ACC_IDLE;
      end else begin
         unique case (state)
            ACC_IDLE: if (req) state <= ACC_DONE;
            default:  state <= ACC_IDLE;
         endcase
      end
   end

   assign ready     = (state == ACC_DONE);
   assign wr_commit = ready && wr;

   // R5: completion lasts one cycle, then the bus is idle again
   p_ready_single_r5: assert property (@(posedge clk) disable iff (rst)
      ready |=> !ready);

   // R5: an idle bus seeing a request completes on the next cycle
   p_ready_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
      (!ready && req) |=> ready);

endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_commit,
   input  logic             ready,
   input  logic [LANES-1:0] be,
   input  logic [BUS_W-1:0] wdata,
   output ctl_t             ctl,
   output logic [BUS_W-1:0] rdata
);

   localparam int unsigned DIV_LANE = DIV_LSB / LANE_W;
   localparam int unsigned SRC_LANE = SRC_LSB / LANE_W;

   logic [BUS_W-1:0] image;
   logic [BUS_W-1:0] merged;
   logic             rsvd_unused;

   always_comb begin
      image                         = '0;
      image[DIV_LSB +: DIV_W]       = ctl.div_sel;
      image[SRC_LSB +: SRC_W]       = ctl.src;
      image[LVL_POS]                = ctl.lvl;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] =
         be[g] ? wdata[g*LANE_W +: LANE_W] : image[g*LANE_W +: LANE_W];
   end

   // reserved positions of the merged word are dropped on purpose
   assign rsvd_unused = ^(merged & ~FIELD_MASK);

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl <= CTL_RESET;
      end else if (wr_commit) begin
         ctl.div_sel <= merged[DIV_LSB +: DIV_W];
         ctl.src     <= src_sel_e'(merged[SRC_LSB +: SRC_W]);
         ctl.lvl     <= merged[LVL_POS];
      end
   end

   assign rdata = ready ? image : '0;

   // R6: a write without the upper lane leaves the ratio field alone
   p_div_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_commit && !be[DIV_LANE]) |=> $stable(ctl.div_sel));

   // R6: a write without the lower lane leaves source and level alone
   p_src_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_commit && !be[SRC_LANE]) |=> ($stable(ctl.src) && $stable(ctl.lvl)));

   // R5: register contents only move on a committed write
   p_ctl_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_commit |=> $stable(ctl));

endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
   parameter int unsigned BASE_LOG2 = 3,
   parameter int unsigned SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);

   localparam int unsigned STEPS = 1 << SEL_W;
   localparam int unsigned CNT_W = BASE_LOG2 + STEPS - 1;

   if (BASE_LOG2 < 1 || CNT_W > 24) begin : g_bad_cfg
      $error("clkctl_div: BASE_LOG2/SEL_W give an unsupported counter width");
   end

   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] act_sel;

   function automatic logic [CNT_W-1:0] limit_of(input logic [SEL_W-1:0] s);
      logic [CNT_W:0] full;
      full = (CNT_W+1)'(1) << (BASE_LOG2 + int'(s));
      return full[CNT_W-1:0] - CNT_W'(1);
   endfunction

   assign tick = (cnt == limit_of(act_sel));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         act_sel <= '0;
      end else if (tick) begin
         cnt     <= '0;
         act_sel <= div_sel;
      end else begin
         cnt     <= cnt + CNT_W'(1);
      end
   end

   // R1: the strobe is never wider than one cycle
   p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R1: the count never runs past the active period
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
      cnt <= limit_of(act_sel));

   // R7: the active ratio moves only at the end of a period
   p_ratio_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(act_sel));

endmodule

// File: rtl/clkctl_ifgen.sv
module clkctl_ifgen #(
   parameter int unsigned IF_DIV = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   if (IF_DIV < 1) begin : g_bad_div
      $error("clkctl_ifgen: IF_DIV must be at least 1");
   end else if (IF_DIV == 1) begin : g_pass
      assign tick = 1'b1;
   end else begin : g_count
      localparam int unsigned W = $clog2(IF_DIV);
      logic [W-1:0] cnt;

      assign tick = (cnt == W'(IF_DIV - 1));

      always_ff @(posedge clk) begin
         if (rst)       cnt <= '0;
         else if (tick) cnt <= '0;
         else           cnt <= cnt + W'(1);
      end

      // R8: interface strobes are separated by idle cycles
      p_if_spacing_r8: assert property (@(posedge clk) disable iff (rst)
         tick |=> !tick);
   end

endmodule

// File: rtl/clkctl_omux.sv
module clkctl_omux
   import clkctl_pkg::*;
#(
   parameter bit REG_PIN = 1'b1
) (
   input  logic     clk,
   input  logic     rst,
   input  src_sel_e src,
   input  logic     lvl,
   input  logic     if_tick,
   input  logic     core_tick,
   output logic     pin
);

   logic nxt;

   always_comb begin
      unique case (src)
         SRC_LEVEL: nxt = lvl;
         SRC_IFCLK: nxt = if_tick;
         SRC_CORE:  nxt = core_tick;
         default:   nxt = 1'b1;
      endcase
   end

   if (REG_PIN) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) pin <= 1'b0;
         else     pin <= nxt;
      end

      // R2: system-clock selection holds the pin high
      p_sys_high_r2: assert property (@(posedge clk) disable iff (rst)
         (src == SRC_SYS) |=> pin);

      // R3: static selection copies the level bit one cycle later
      p_level_copy_r3: assert property (@(posedge clk) disable iff (rst)
         (src == SRC_LEVEL) |=> (pin == $past(lvl)));
   end else begin : g_comb
      assign pin = nxt;
   end

endmodule

// File: rtl/clk_ratio_ctl.sv
module clk_ratio_ctl
   import clkctl_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 3,
   parameter int unsigned IF_DIV    = 2,
   parameter bit          REG_PIN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        req,
   input  logic        wr,
   input  logic [1:0]  be,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   output logic        ready,
   output logic        core_en,
   output logic        if_en,
   output logic        clk_pin
);

   if (BUS_W % LANE_W != 0 || LANES != 2) begin : g_bad_bus
      $error("clk_ratio_ctl: bus width must split into two byte lanes");
   end
   if (DIV_LSB + DIV_W > BUS_W || SRC_LSB + SRC_W > BUS_W || LVL_POS >= BUS_W) begin : g_bad_map
      $error("clk_ratio_ctl: a field lies outside the bus word");
   end

   logic wr_commit;
   ctl_t ctl;

   clkctl_bus u_bus (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .wr        (wr),
      .ready     (ready),
      .wr_commit (wr_commit)
   );

   clkctl_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_commit (wr_commit),
      .ready     (ready),
      .be        (be),
      .wdata     (wdata),
      .ctl       (ctl),
      .rdata     (rdata)
   );

   clkctl_div #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (DIV_W)
   ) u_div (
      .clk     (clk),
      .rst     (rst),
      .div_sel (ctl.div_sel),
      .tick    (core_en)
   );

   clkctl_ifgen #(
      .IF_DIV (IF_DIV)
   ) u_ifgen (
      .clk  (clk),
      .rst  (rst),
      .tick (if_en)
   );

   clkctl_omux #(
      .REG_PIN (REG_PIN)
   ) u_omux (
      .clk       (clk),
      .rst       (rst),
      .src       (ctl.src),
      .lvl       (ctl.lvl),
      .if_tick   (if_en),
      .core_tick (core_en),
      .pin       (clk_pin)
   );

   // R4: reserved positions never show up on a read
   p_rsvd_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
      ready |-> ((rdata & ~FIELD_MASK) == '0));

   // R5: outside the completing cycle the read bus is quiet
   p_rdata_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !ready |-> (rdata == '0));

endmodule

// File: tb/clk_ratio_ctl_bench.sv
module clk_ratio_ctl_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0;
   logic        wr  = 1'b0;
   logic [1:0]  be  = 2'b00;
   logic [15:0] wdata = 16'h0000;
   logic [15:0] rdata;
   logic        ready, core_en, if_en, clk_pin;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   clk_ratio_ctl u_clk_ratio_ctl (
      .clk(clk), .rst(rst), .req(req), .wr(wr), .be(be), .wdata(wdata),
      .rdata(rdata), .ready(ready), .core_en(core_en), .if_en(if_en),
      .clk_pin(clk_pin)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Called right after a negedge; returns after two more negedges.
   task automatic bus_acc(input bit w, input logic [1:0] b, input logic [15:0] d,
                          output logic [15:0] rd);
      req = 1'b1; wr = w; be = b; wdata = d;
      @(negedge clk);
      rd  = rdata;
      req = 1'b0;
      @(negedge clk);
      wr = 1'b0; be = 2'b00; wdata = 16'h0000;
   endtask

   task automatic wr_reg(input logic [1:0] b, input logic [15:0] d);
      logic [15:0] rd;
      bus_acc(1'b1, b, d, rd);
   endtask

   task automatic rd_reg(output logic [15:0] v);
      bus_acc(1'b0, 2'b00, 16'h0000, v);
   endtask

   task automatic edges_to_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!core_en && n < 300);
   endtask

   task automatic t_reset;
      int n;
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(core_en == 1'b0, "R9 core_en low after reset", core_en, 0);
      chk(clk_pin == 1'b0, "R9 pin low after reset", clk_pin, 0);
      chk(ready == 1'b0 && rdata == 16'h0, "R9 bus idle after reset", rdata, 0);
      edges_to_tick(n);
      chk(n == 7, "R9 first core tick in 8th cycle", n, 7);
      rd_reg(v);
      chk(v == 16'h0000, "R9 register reset value", v, 0);
   endtask

   task automatic t_handshake;
      req = 1'b1; wr = 1'b0;
      chk(ready == 1'b0, "R5 ready low in first cycle", ready, 0);
      @(negedge clk);
      chk(ready == 1'b1, "R5 ready high in second cycle", ready, 1);
      @(negedge clk);
      chk(ready == 1'b0, "R5 ready drops after access", ready, 0);
      @(negedge clk);
      chk(ready == 1'b1, "R5 back-to-back second access", ready, 1);
      req = 1'b0;
      @(negedge clk);
      chk(ready == 1'b0 && rdata == 16'h0, "R5 rdata zero when idle", rdata, 0);
   endtask

   task automatic t_reserved;
      logic [15:0] v;
      wr_reg(2'b11, 16'hFFFF);
      rd_reg(v);
      chk(v == 16'h0368, "R4 reserved bits read zero", v, 16'h0368);
      wr_reg(2'b11, 16'h0000);
      rd_reg(v);
      chk(v == 16'h0000, "R5 full write clears fields", v, 0);
   endtask

   task automatic t_lanes;
      logic [15:0] v;
      wr_reg(2'b10, 16'hFFFF);
      rd_reg(v);
      chk(v == 16'h0300, "R6 upper lane only", v, 16'h0300);
      wr_reg(2'b01, 16'h0068);
      rd_reg(v);
      chk(v == 16'h0368, "R6 lower lane keeps upper", v, 16'h0368);
      wr_reg(2'b10, 16'h0000);
      rd_reg(v);
      chk(v == 16'h0068, "R6 upper lane clears ratio only", v, 16'h0068);
      wr_reg(2'b00, 16'hFFFF);
      rd_reg(v);
      chk(v == 16'h0068, "R6 no lane enabled changes nothing", v, 16'h0068);
      wr_reg(2'b11, 16'h0000);
   endtask

   task automatic t_ratios;
      int n;
      for (int s = 0; s < 4; s++) begin
         wr_reg(2'b10, 16'(s << 8));
         edges_to_tick(n);
         edges_to_tick(n);
         chk(n == (8 << s), $sformatf("R1 period for select %0d", s), n, 8 << s);
         @(negedge clk);
         chk(core_en == 1'b0, "R1 strobe one cycle wide", core_en, 0);
      end
   endtask

   // Ratio is 64 on entry.
   task automatic t_defer;
      int n;
      edges_to_tick(n);
      repeat (63) @(negedge clk);          // count now one below its limit
      wr_reg(2'b10, 16'h0000);             // commit edge == terminal edge
      edges_to_tick(n);
      chk(n == 63, "R7 coincident write keeps old period", n, 63);
      edges_to_tick(n);
      chk(n == 8, "R7 new ratio after coincident write", n, 8);
      wr_reg(2'b10, 16'h0100);             // starts on a tick cycle
      edges_to_tick(n);
      chk(n + 2 == 8, "R7 mid-period write keeps old period", n + 2, 8);
      edges_to_tick(n);
      chk(n == 16, "R7 new ratio after mid-period write", n, 16);
      wr_reg(2'b10, 16'h0000);
   endtask

   task automatic t_ifclk;
      int bad = 0;
      logic prev;
      @(negedge clk);
      prev = if_en;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (if_en == prev) bad++;
         prev = if_en;
      end
      chk(bad == 0, "R8 interface strobe alternates", bad, 0);
   endtask

   task automatic pin_follow(input logic [15:0] d, input int which, input string tag);
      int bad = 0;
      logic prev;
      wr_reg(2'b01, d);
      @(negedge clk);
      prev = (which == 1) ? if_en : core_en;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (clk_pin !== prev) bad++;
         prev = (which == 1) ? if_en : core_en;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic t_pin;
      int ones = 0;
      wr_reg(2'b01, 16'h0008);
      @(negedge clk);
      chk(clk_pin == 1'b1, "R3 level bit drives pin", clk_pin, 1);
      wr_reg(2'b10, 16'h0000);
      @(negedge clk);
      chk(clk_pin == 1'b1, "R6 upper-lane write leaves level", clk_pin, 1);
      wr_reg(2'b01, 16'h0000);
      @(negedge clk);
      chk(clk_pin == 1'b0, "R3 level bit cleared on pin", clk_pin, 0);
      wr_reg(2'b01, 16'h0060);
      @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (clk_pin) ones++;
      end
      chk(ones == 10, "R2 system clock select holds pin high", ones, 10);
      pin_follow(16'h0020, 1, "R2 pin follows interface strobe");
      pin_follow(16'h0040, 2, "R2 pin follows processor strobe");
      wr_reg(2'b01, 16'h0000);
   endtask

   task automatic t_reset_mid;
      int n;
      logic [15:0] v;
      wr_reg(2'b11, 16'h0328);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(clk_pin == 1'b0, "R9 pin cleared by reset", clk_pin, 0);
      chk(if_en == 1'b0, "R8 if strobe low first cycle", if_en, 0);
      @(negedge clk);
      chk(if_en == 1'b1, "R8 if strobe high second cycle", if_en, 1);
      edges_to_tick(n);
      chk(n == 6, "R9 divider restarts at ratio 8", n, 6);
      rd_reg(v);
      chk(v == 16'h0000, "R9 fields back to default", v, 0);
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      t_reset();
      t_handshake();
      t_reserved();
      t_lanes();
      t_ratios();
      t_defer();
      t_ifclk();
      t_pin();
      t_reset_mid();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before tests completed");
         report();
         $finish;
      end
   end

endmodule